// File: doc/BRIEF.md
# Run-Length Byte Stream Expander

This block turns a run-length coded byte stream back into its plain form. A pulse on `start_i` arms it. It then takes a four-byte little-endian header from the input stream. The low byte of the header is a format tag, and the block does not check it. The upper three bytes give the number of plain bytes to produce. After the header, the block reads a sequence of control bytes. Each control byte opens one of two kinds of block. A repeat block emits the one byte that follows it several times. A copy block passes through a number of the bytes that follow it.

Both sides use valid/ready byte streams. When the declared length has been produced, the block appends zero bytes until the total output is a multiple of four bytes. It then raises `done_o` for one cycle.

The output has two modes. In byte mode each beat carries one byte. In halfword mode pairs of bytes are packed into 16-bit beats. The mode is chosen with `halfword_i` and latched when the start pulse is accepted.

Top module: `rle_expander`

## Requirements
- R1: After reset, `in_ready_o`, `out_valid_o` and `done_o` are all low until a start pulse arrives.
- R2: A start pulse while idle begins decoding. The header is the next four accepted input bytes. Byte 0 is ignored whatever its value. Bytes 1, 2 and 3 are the low, middle and high bytes of a 24-bit output length. A start pulse during decoding has no effect.
- R3: A control byte with bit 7 = 1 opens a repeat block. The next input byte is emitted ((control & 0x7F) + 3) times, so between 3 and 130 times.
- R4: A control byte with bit 7 = 0 opens a copy block. The next ((control & 0x7F) + 1) input bytes, between 1 and 128 of them, are emitted unchanged and in order.
- R5: Output stops at the declared length, even when that cuts a repeat or copy block short. The input bytes of a copy block that were not emitted are left unaccepted: `in_ready_o` stays low for them.
- R6: After the declared length, (4 - length) mod 4 zero bytes are emitted. A length of 0 produces no output at all.
- R7: In byte mode each beat carries its byte on `out_data_o[7:0]`, with `out_data_o[15:8]` = 0. In halfword mode each beat carries two consecutive output bytes. The earlier (even) byte is in bits 7:0 and the later byte is in bits 15:8.
- R8: In halfword mode, when the data length is odd, the first padding zero becomes the upper byte of the last data halfword. Any remaining padding is emitted as 0x0000 halfwords.
- R9: `done_o` is high for exactly one cycle. That cycle is the one right after the clock edge that accepts the final output beat. With a zero length it follows the header.
- R10: While `out_valid_o` is high and `out_ready_i` is low, no input byte is accepted, and the result is the same as with an always-ready output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; honoured only while idle |
| halfword_i | input | 1 | 1 selects 16-bit output beats; latched at start |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Block accepts the input byte |
| out_valid_o | output | 1 | Output beat valid |
| out_data_o | output | 16 | Output beat (byte mode uses bits 7:0) |
| out_ready_i | input | 1 | Sink accepts the output beat |
| done_o | output | 1 | One-cycle pulse after the last beat |

## Verification
The assertions check four things on every cycle:
- no input is taken while an output beat is stalled;
- the done pulse lasts a single cycle, and no output beat follows it;
- the number of bytes emitted is a multiple of four whenever done is raised.

Other behaviour can only be shown by the bench's scenarios, each compared with an independent model of the format:
- the values and order of the expanded bytes;
- the repeat and copy length biases;
- truncation, and the copy-block bytes it leaves unaccepted;
- the halfword pairing when the data ends on an odd byte;
- the exact cycle of the done pulse;
- ignoring a start pulse during decoding.

// File: rtl/rle_pkg.sv
package rle_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned LEN_W   = 24;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned HDR_N   = 4;
  localparam int unsigned IDX_W   = $clog2(HDR_N);
  localparam int unsigned PAD_W   = 2;
  localparam int unsigned OUT_W   = 2 * BYTE_W;
  localparam int unsigned RUN_BIAS = 3;
  localparam int unsigned LIT_BIAS = 1;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_CTRL, S_RUNVAL, S_RUN, S_LIT, S_PAD, S_DONE
  } rle_state_e;
endpackage

// File: rtl/rle_seq.sv
module rle_seq
  import rle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              emit_valid_o,
  output logic [BYTE_W-1:0] emit_byte_o,
  input  logic              emit_ready_i,
  output logic              launch_o,
  output logic              done_o
);
  rle_state_e        state_q, state_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PAD_W-1:0]  pad_q, pad_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BYTE_W-1:0] val_q, val_d;
  logic              adv;
  logic              last_data;
  logic [CNT_W-1:0]  ctrl_len;

  assign last_data = (rem_q == LEN_W'(1));
  assign ctrl_len  = in_data_i[BYTE_W-1] ?
                     (CNT_W'(in_data_i[BYTE_W-2:0]) + CNT_W'(RUN_BIAS)) :
                     (CNT_W'(in_data_i[BYTE_W-2:0]) + CNT_W'(LIT_BIAS));

  always_comb begin
    state_d      = state_q;
    rem_d        = rem_q;
    cnt_d        = cnt_q;
    pad_d        = pad_q;
    idx_d        = idx_q;
    val_d        = val_q;
    in_ready_o   = 1'b0;
    emit_valid_o = 1'b0;
    emit_byte_o  = '0;
    launch_o     = 1'b0;
    adv          = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start_i) begin
          launch_o = 1'b1;
          idx_d    = '0;
          rem_d    = '0;
          state_d  = S_HDR;
        end
      end
      S_HDR: begin
        in_ready_o = 1'b1;
        if (in_valid_i) begin
          idx_d = idx_q + IDX_W'(1);
          if (idx_q != '0) rem_d = {in_data_i, rem_q[LEN_W-1:BYTE_W]};
          if (idx_q == IDX_W'(HDR_N - 1)) begin
            pad_d   = PAD_W'(~rem_d[PAD_W-1:0]) + PAD_W'(1);
            state_d = (rem_d == '0) ? S_DONE : S_CTRL;
          end
        end
      end
      S_CTRL: begin
        in_ready_o = 1'b1;
        if (in_valid_i) begin
          cnt_d   = ctrl_len;
          state_d = in_data_i[BYTE_W-1] ? S_RUNVAL : S_LIT;
        end
      end
      S_RUNVAL: begin
        in_ready_o = 1'b1;
        if (in_valid_i) begin
          val_d   = in_data_i;
          state_d = S_RUN;
        end
      end
      S_RUN: begin
        emit_valid_o = 1'b1;
        emit_byte_o  = val_q;
        adv          = emit_ready_i;
      end
      S_LIT: begin
        emit_valid_o = in_valid_i;
        emit_byte_o  = in_data_i;
        in_ready_o   = emit_ready_i;
        adv          = in_valid_i && emit_ready_i;
      end
      S_PAD: begin
        emit_valid_o = 1'b1;
        emit_byte_o  = '0;
        if (emit_ready_i) begin
          pad_d = pad_q - PAD_W'(1);
          if (pad_q == PAD_W'(1)) state_d = S_DONE;
        end
      end
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (adv) begin
      rem_d = rem_q - LEN_W'(1);
      cnt_d = cnt_q - CNT_W'(1);
      if (last_data)                state_d = (pad_q == '0) ? S_DONE : S_PAD;
      else if (cnt_q == CNT_W'(1))  state_d = S_CTRL;
    end
  end

  assign done_o = (state_q == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rem_q   <= '0;
      cnt_q   <= '0;
      pad_q   <= '0;
      idx_q   <= '0;
      val_q   <= '0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      cnt_q   <= cnt_d;
      pad_q   <= pad_d;
      idx_q   <= idx_d;
      if (state_q == S_RUNVAL) val_q <= val_d;
    end
  end
endmodule

// File: rtl/rle_pack.sv
module rle_pack
  import rle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              half_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              byte_ready_o,
  output logic              out_valid_o,
  output logic [OUT_W-1:0]  out_data_o,
  input  logic              out_ready_i
);
  logic              phase_q;
  logic [BYTE_W-1:0] low_q;
  logic              take;

  always_comb begin
    if (!half_i) begin
      out_valid_o  = byte_valid_i;
      out_data_o   = {{BYTE_W{1'b0}}, byte_i};
      byte_ready_o = out_ready_i;
    end else if (!phase_q) begin
      out_valid_o  = 1'b0;
      out_data_o   = '0;
      byte_ready_o = 1'b1;
    end else begin
      out_valid_o  = byte_valid_i;
      out_data_o   = {byte_i, low_q};
      byte_ready_o = out_ready_i;
    end
  end

  assign take = half_i && byte_valid_i && byte_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      low_q   <= '0;
    end else begin
      if (clr_i)     phase_q <= 1'b0;
      else if (take) phase_q <= ~phase_q;
      if (take && !phase_q) low_q <= byte_i;
    end
  end
endmodule

// File: rtl/rle_expander.sv
module rle_expander
  import rle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              halfword_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [OUT_W-1:0]  out_data_o,
  input  logic              out_ready_i,
  output logic              done_o
);
  logic              launch;
  logic              mode_q;
  logic              emit_valid;
  logic              emit_ready;
  logic [BYTE_W-1:0] emit_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= 1'b0;
    else if (launch) mode_q <= halfword_i;
  end

  rle_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .in_valid_i   (in_valid_i),
    .in_data_i    (in_data_i),
    .in_ready_o   (in_ready_o),
    .emit_valid_o (emit_valid),
    .emit_byte_o  (emit_byte),
    .emit_ready_i (emit_ready),
    .launch_o     (launch),
    .done_o       (done_o)
  );

  rle_pack u_pack (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (launch),
    .half_i       (mode_q),
    .byte_valid_i (emit_valid),
    .byte_i       (emit_byte),
    .byte_ready_o (emit_ready),
    .out_valid_o  (out_valid_o),
    .out_data_o   (out_data_o),
    .out_ready_i  (out_ready_i)
  );
endmodule

// File: rtl/rle_expander_chk.sv
module rle_expander_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic out_valid_o,
  input logic out_ready_i,
  input logic done_o,
  input logic mode_q
);
  logic [1:0] bytes_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           bytes_q <= 2'd0;
    else if (done_o)                      bytes_q <= 2'd0;
    else if (out_valid_o && out_ready_i)  bytes_q <= bytes_q + (mode_q ? 2'd2 : 2'd1);
  end

  // R10: stalled output blocks input
  a_r10_no_input_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |-> !(in_valid_i && in_ready_o));

  // R9: done lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: no beat after done
  a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !out_valid_o);

  // R6: total output aligned to four bytes
  a_r6_aligned_total: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (bytes_q == 2'd0));
endmodule

bind rle_expander rle_expander_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .done_o      (done_o),
  .mode_q      (mode_q)
);

// File: tb/sim_rle_expander.sv
`timescale 1ns/1ps
module sim_rle_expander;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        halfword_i;
  logic        in_valid_i;
  logic [7:0]  in_data_i;
  logic        in_ready_o;
  logic        out_valid_o;
  logic [15:0] out_data_o;
  logic        out_ready_i;
  logic        done_o;

  rle_expander u0 (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  int ptr = 0;
  int src_len = 0;
  logic [7:0]  src [0:1023];
  logic [15:0] got [0:1023];
  logic [15:0] expv [0:1023];
  int nbeats = 0;
  int exp_nb = 0;
  int exp_cons = 0;
  int donecnt = 0;
  int done_cyc = 0;
  int last_cyc = 0;
  logic stall = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic running = 1'b0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint expd);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expd);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // input and sink driver
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    in_valid_i  = running && (ptr < src_len) && (!stall || lfsr[3]);
    in_data_i   = (ptr < src_len) ? src[ptr] : 8'h00;
    out_ready_i = !stall || lfsr[0];
  end

  // handshake monitor and watchdog
  initial forever begin
    @(posedge clk);
    cyc++;
    if (rst_n) begin
      if (in_valid_i && in_ready_o) ptr++;
      if (out_valid_o && out_ready_i) begin
        got[nbeats] = out_data_o;
        nbeats++;
        last_cyc = cyc;
      end
      if (done_o) begin
        donecnt++;
        done_cyc = cyc;
      end
    end
    if (cyc > 150000) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic model(input logic half);
    logic [7:0] b [0:1023];
    int nb, p, rem, len, n, pad;
    logic [7:0] c, v;
    len = int'(src[1]) | (int'(src[2]) << 8) | (int'(src[3]) << 16);
    p = 4; rem = len; nb = 0;
    while (rem > 0) begin
      c = src[p]; p++;
      if (c[7]) begin
        n = int'(c[6:0]) + 3; v = src[p]; p++;
        while (n > 0 && rem > 0) begin b[nb] = v; nb++; n--; rem--; end
      end else begin
        n = int'(c[6:0]) + 1;
        while (n > 0 && rem > 0) begin b[nb] = src[p]; p++; nb++; n--; rem--; end
      end
    end
    pad = (4 - (len % 4)) % 4;
    for (int k = 0; k < pad; k++) begin b[nb] = 8'h00; nb++; end
    exp_cons = p;
    if (half) begin
      exp_nb = nb / 2;
      for (int k = 0; k < exp_nb; k++) expv[k] = {b[2*k+1], b[2*k]};
    end else begin
      exp_nb = nb;
      for (int k = 0; k < nb; k++) expv[k] = {8'h00, b[k]};
    end
  endtask

  task automatic run_case(input string tag, input logic half, input logic stl, input logic extra_start);
    int w;
    int bad;
    model(half);
    ptr = 0; nbeats = 0; donecnt = 0; stall = stl;
    @(negedge clk);
    running = 1'b1; halfword_i = half; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; halfword_i = ~half;
    w = 0;
    while (donecnt == 0 && w < 20000) begin
      @(negedge clk);
      w++;
      start_i = extra_start && (w == 30);
    end
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    running = 1'b0;
    chk(nbeats == exp_nb, {tag, " beat count"}, nbeats, exp_nb);
    bad = 0;
    for (int k = 0; k < exp_nb && k < nbeats; k++)
      if (got[k] !== expv[k]) begin
        if (bad == 0) chk(1'b0, {tag, " beat data"}, got[k], expv[k]);
        bad++;
      end
    if (bad == 0) chk(1'b1, tag, 0, 0);
    chk(ptr == exp_cons, {tag, " R5 input bytes accepted"}, ptr, exp_cons);
    chk(donecnt == 1, {tag, " R9 done pulses"}, donecnt, 1);
    if (exp_nb > 0)
      chk(done_cyc == last_cyc + 1, {tag, " R9 done timing"}, done_cyc - last_cyc, 1);
  endtask

  task automatic hdr(input logic [7:0] sig, input int len);
    src[0] = sig; src[1] = len[7:0]; src[2] = len[15:8]; src[3] = len[23:16];
  endtask

  task automatic t_reset();
    #1;
    chk(!in_ready_o && !out_valid_o && !done_o, "R1 idle outputs",
        {in_ready_o, out_valid_o, done_o}, 0);
  endtask

  task automatic t_run_byte();
    hdr(8'h00, 8); src[4] = 8'h85; src[5] = 8'hAA; src_len = 6;
    run_case("R2 R3 run byte mode", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_lit_pad();
    hdr(8'h30, 5); src[4] = 8'h04;
    for (int k = 0; k < 5; k++) src[5+k] = 8'(8'h11 * (k + 1));
    src_len = 10;
    run_case("R4 R6 literal with pad 3", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_trunc_run();
    hdr(8'h30, 6); src[4] = 8'h01; src[5] = 8'h12; src[6] = 8'h34;
    src[7] = 8'h82; src[8] = 8'h55; src_len = 9;
    run_case("R5 truncated run with stall", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_trunc_lit();
    hdr(8'h30, 3); src[4] = 8'h05;
    for (int k = 0; k < 6; k++) src[5+k] = 8'(8'hC0 + k);
    src_len = 11;
    run_case("R5 truncated literal", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_half_odd();
    hdr(8'h30, 7); src[4] = 8'h06;
    for (int k = 0; k < 7; k++) src[5+k] = 8'(8'h21 + k);
    src_len = 12;
    run_case("R7 R8 halfword odd length", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_half_pad3();
    hdr(8'h30, 5); src[4] = 8'h80; src[5] = 8'h9C; src[6] = 8'h01;
    src[7] = 8'h3A; src[8] = 8'h3B; src_len = 9;
    run_case("R8 halfword pad 3", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_zero();
    hdr(8'h30, 0); src[4] = 8'h77; src_len = 5;
    run_case("R6 R9 zero length", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_long_stall();
    hdr(8'h30, 258); src[4] = 8'hFF; src[5] = 8'hAB; src[6] = 8'h7F;
    for (int k = 0; k < 128; k++) src[7+k] = 8'(k * 3 + 1);
    src_len = 135;
    run_case("R10 R2 long halfword stall busy start", 1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; halfword_i = 1'b0;
    in_valid_i = 1'b0; in_data_i = 8'h00; out_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_run_byte();
    t_lit_pad();
    t_trunc_run();
    t_trunc_lit();
    t_half_odd();
    t_half_pad3();
    t_zero();
    t_long_stall();
    finish_run();
  end
endmodule